// File: doc/BRIEF.md
# Start-up Reset Supervisor

This block watches a shared, wired-low reset line while a system powers up or restarts. It first pulls the line low itself for a short or a long reset pulse. It then times how long the line stays low, counted from the start of that low phase. Once the line is released, it opens a bounded start-up window. In that window the host must deliver a watchdog-initialization strobe. While the window is open, only a small set of register writes is accepted.

Three failures escalate the operating mode: a line held low past the monitoring limit (clamped), a window that expires without the strobe, or a new falling edge on the line inside the window (chatter). The first failure takes Start-up to Restart, with a fresh long reset pulse and a repeat of the whole sequence. A failure while in Restart lands in Fail-safe. If the line is low because of primary-supply undervoltage when the monitoring limit runs out, the block goes to Fail-safe at once and asserts a supply-disable output. Fail-safe is left only through the synchronous power-on reset. Each escalation raises a one-cycle error flag and latches a cause code.

All durations are clock-cycle counts set by parameters. The pin level passes through a two-flop synchronizer before any level or edge decision is made.

Top module: `boot_reset_guard`

## Requirements
- R1: While `rst_n` is low and in the cycle after its release, `mode` is Start-up (0), `rst_line_drive` is 1, `supply_off` is 0, `err_pulse` is 0 and `err_cause` is none (0).
- R2: After power-on reset the block drives the line low for exactly PULSE_SHORT cycles when `long_pulse_sel` was 0 during reset, and for exactly PULSE_LONG cycles when it was 1.
- R3: If the synchronized line is still low MON_CYCLES cycles after a low phase began, with no undervoltage, the block escalates with cause clamp (1). Start-up goes to Restart (1).
- R4: A line released within the monitoring limit opens the start-up window. An `init_strobe` in the window moves `mode` to Normal (2), and the mode then stays there.
- R5: If the window runs START_CYCLES cycles without a strobe while in Start-up, `mode` becomes Restart, the cause is init timeout (2), and a PULSE_LONG reset pulse is driven before the sequence repeats.
- R6: Any escalation while in Restart gives Fail-safe (3). Fail-safe holds until `rst_n`, and the line is not driven in Fail-safe.
- R7: A falling edge of the synchronized line inside the window escalates immediately with cause glitch (3).
- R8: While `uv_flag` is high outside Fail-safe and Normal, the line is driven low. A monitoring expiry with `uv_flag` high goes directly to Fail-safe with cause undervoltage (4) and sets `supply_off`.
- R9: Inside the window, `wr_permit` is granted only for addresses GP_BASE to GP_BASE+GP_COUNT-1 (default 0 to 3), MODE_ADDR (8), and SPECIAL_ADDR (9). SPECIAL_ADDR is granted once per power-on only. Writes are granted for any address in Normal and refused in every other phase.
- R10: Each escalation sets `err_pulse` for exactly one cycle and latches its cause in `err_cause`, which holds until the next escalation or reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| rst_line_in | input | 1 | Sampled level of the shared reset line (1 = released) |
| uv_flag | input | 1 | Primary-supply undervoltage indication |
| init_strobe | input | 1 | Host watchdog-initialization strobe |
| long_pulse_sel | input | 1 | Selects the long power-up reset pulse, sampled during reset |
| wr_req | input | 1 | Register write request |
| wr_addr | input | ADDR_W | Register write address |
| rst_line_drive | output | 1 | 1 pulls the reset line low |
| mode | output | 2 | 0 Start-up, 1 Restart, 2 Normal, 3 Fail-safe |
| supply_off | output | 1 | Disables the primary supply after an undervoltage escalation |
| wr_permit | output | 1 | The current write request is accepted |
| err_pulse | output | 1 | One-cycle escalation flag |
| err_cause | output | 3 | 0 none, 1 clamp, 2 init timeout, 3 glitch, 4 undervoltage |

## Verification
A wrong phase or counter value shows at the ports within one clock. The line drive, `mode` or `wr_permit` then differ from the reference model in the next compared cycle. Two kinds of fault stay hidden until an escalation: an off-by-one in the monitoring or window counter, and a missing synchronizer stage. Both appear as `mode` and `err_pulse` changing one cycle early or late, so the bench checks every cycle rather than only end states. A stale once-only write flag appears only on the second special-register write in the window.

// File: rtl/brg_pkg.sv
// Shared encodings for the start-up reset supervisor.
// Assumes: the mode and cause values are visible at the ports and are fixed.
package brg_pkg;

    typedef enum logic [1:0] {
        MODE_STARTUP  = 2'd0,
        MODE_RESTART  = 2'd1,
        MODE_NORMAL   = 2'd2,
        MODE_FAILSAFE = 2'd3
    } brg_mode_e;

    typedef enum logic [2:0] {
        CAUSE_NONE      = 3'd0,
        CAUSE_CLAMP     = 3'd1,
        CAUSE_TIMEOUT   = 3'd2,
        CAUSE_GLITCH    = 3'd3,
        CAUSE_UNDERVOLT = 3'd4
    } brg_cause_e;

    typedef enum logic [1:0] {
        PH_PULSE   = 2'd0,
        PH_MONITOR = 2'd1,
        PH_WINDOW  = 2'd2,
        PH_IDLE    = 2'd3
    } brg_phase_e;

endpackage

// File: rtl/brg_pin_sync.sv
// Synchronizes the sampled reset-line level through STAGES flops and flags
// a high-to-low transition of the synchronized level.
// Assumes: STAGES >= 2; a reset value of low never produces a false edge.
module brg_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_raw,
    output logic pin_sync,
    output logic pin_fall
);

    logic [STAGES-1:0] chain_q;
    logic              last_q;

    // Shift the raw level through the chain and keep the previous output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '0;
            last_q  <= 1'b0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], pin_raw};
            last_q  <= chain_q[STAGES-1];
        end
    end

    assign pin_sync = chain_q[STAGES-1];
    assign pin_fall = last_q & ~chain_q[STAGES-1];

endmodule

// File: rtl/brg_write_gate.sv
// Decides whether a register write request is accepted in the current phase.
// Inside the start-up window only the general-purpose range, the mode
// register and a once-per-power-on special register are accepted.
// Assumes: the address parameters fit in ADDR_W bits.
module brg_write_gate #(
    parameter int ADDR_W       = 4,
    parameter int GP_BASE      = 0,
    parameter int GP_COUNT     = 4,
    parameter int MODE_ADDR    = 8,
    parameter int SPECIAL_ADDR = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_window,
    input  logic              in_normal,
    input  logic              wr_req,
    input  logic [ADDR_W-1:0] wr_addr,
    output logic              wr_permit
);

    localparam int                GP_END = GP_BASE + GP_COUNT;
    localparam logic [ADDR_W:0]   GP_LO  = (ADDR_W+1)'(GP_BASE);
    localparam logic [ADDR_W:0]   GP_HI  = (ADDR_W+1)'(GP_END);
    localparam logic [ADDR_W-1:0] MODE_A = ADDR_W'(MODE_ADDR);
    localparam logic [ADDR_W-1:0] SPEC_A = ADDR_W'(SPECIAL_ADDR);

    logic special_used_q;
    logic is_gp, is_mode, is_spec, win_ok;

    // Classify the address and combine it with the phase.
    always_comb begin
        is_gp     = ({1'b0, wr_addr} >= GP_LO) && ({1'b0, wr_addr} < GP_HI);
        is_mode   = (wr_addr == MODE_A);
        is_spec   = (wr_addr == SPEC_A);
        win_ok    = is_gp | is_mode | (is_spec & ~special_used_q);
        wr_permit = wr_req & (in_normal | (in_window & win_ok));
    end

    // Remember that the special register has been written since power-on.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            special_used_q <= 1'b0;
        end else if (wr_permit && is_spec) begin
            special_used_q <= 1'b1;
        end
    end

endmodule

// File: rtl/boot_reset_guard.sv
// Start-up reset supervisor: drives a power-up reset pulse and times the
// low phase of the shared reset line. It opens a start-up window for the
// host's watchdog initialization and escalates Start-up -> Restart ->
// Fail-safe on a clamped line, a missed initialization or a glitch.
// Assumes: PULSE_LONG < MON_CYCLES; all durations are clock cycles.
module boot_reset_guard #(
    parameter int MON_CYCLES   = 64,
    parameter int START_CYCLES = 96,
    parameter int PULSE_SHORT  = 6,
    parameter int PULSE_LONG   = 20,
    parameter int SYNC_STAGES  = 2,
    parameter int ADDR_W       = 4,
    parameter int GP_BASE      = 0,
    parameter int GP_COUNT     = 4,
    parameter int MODE_ADDR    = 8,
    parameter int SPECIAL_ADDR = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rst_line_in,
    input  logic              uv_flag,
    input  logic              init_strobe,
    input  logic              long_pulse_sel,
    input  logic              wr_req,
    input  logic [ADDR_W-1:0] wr_addr,
    output logic              rst_line_drive,
    output logic [1:0]        mode,
    output logic              supply_off,
    output logic              wr_permit,
    output logic              err_pulse,
    output logic [2:0]        err_cause
);

    import brg_pkg::*;

    localparam int               CNT_MAX    = (MON_CYCLES > START_CYCLES) ? MON_CYCLES : START_CYCLES;
    localparam int               CNT_W      = $clog2(CNT_MAX + 1);
    localparam logic [CNT_W-1:0] MON_LAST   = CNT_W'(MON_CYCLES - 1);
    localparam logic [CNT_W-1:0] START_LAST = CNT_W'(START_CYCLES - 1);
    localparam logic [CNT_W-1:0] PLEN_SHORT = CNT_W'(PULSE_SHORT);
    localparam logic [CNT_W-1:0] PLEN_LONG  = CNT_W'(PULSE_LONG);

    brg_mode_e        mode_q, mode_d;
    brg_phase_e       phase_q, phase_d;
    brg_cause_e       cause_q, esc_cause;
    logic [CNT_W-1:0] cnt_q, cnt_d, plen_q, plen_d;
    logic             supply_q, supply_d;
    logic             err_q, esc;
    logic             pin_sync, pin_fall;

    brg_pin_sync #(
        .STAGES (SYNC_STAGES)
    ) i_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_raw  (rst_line_in),
        .pin_sync (pin_sync),
        .pin_fall (pin_fall)
    );

    brg_write_gate #(
        .ADDR_W       (ADDR_W),
        .GP_BASE      (GP_BASE),
        .GP_COUNT     (GP_COUNT),
        .MODE_ADDR    (MODE_ADDR),
        .SPECIAL_ADDR (SPECIAL_ADDR)
    ) i_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_window (phase_q == PH_WINDOW),
        .in_normal (mode_q == MODE_NORMAL),
        .wr_req    (wr_req),
        .wr_addr   (wr_addr),
        .wr_permit (wr_permit)
    );

    // Phase sequencing, timing and escalation decisions.
    always_comb begin
        mode_d    = mode_q;
        phase_d   = phase_q;
        cnt_d     = cnt_q;
        plen_d    = plen_q;
        supply_d  = supply_q;
        esc       = 1'b0;
        esc_cause = CAUSE_NONE;
        case (phase_q)
            PH_PULSE: begin
                cnt_d = cnt_q + 1'b1;
                if (cnt_d == plen_q) begin
                    phase_d = PH_MONITOR;
                end
            end
            PH_MONITOR: begin
                if (pin_sync) begin
                    phase_d = PH_WINDOW;
                    cnt_d   = '0;
                end else if (cnt_q == MON_LAST) begin
                    esc       = 1'b1;
                    esc_cause = uv_flag ? CAUSE_UNDERVOLT : CAUSE_CLAMP;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            PH_WINDOW: begin
                if (pin_fall) begin
                    esc       = 1'b1;
                    esc_cause = CAUSE_GLITCH;
                end else if (init_strobe) begin
                    phase_d = PH_IDLE;
                    mode_d  = MODE_NORMAL;
                end else if (cnt_q == START_LAST) begin
                    esc       = 1'b1;
                    esc_cause = CAUSE_TIMEOUT;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            default: begin
            end
        endcase
        if (esc) begin
            if (esc_cause == CAUSE_UNDERVOLT || mode_q == MODE_RESTART) begin
                mode_d   = MODE_FAILSAFE;
                phase_d  = PH_IDLE;
                supply_d = (esc_cause == CAUSE_UNDERVOLT);
            end else begin
                mode_d  = MODE_RESTART;
                phase_d = PH_PULSE;
                cnt_d   = '0;
                plen_d  = PLEN_LONG;
            end
        end
    end

    // State registers; the power-up pulse length is chosen during reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q   <= MODE_STARTUP;
            phase_q  <= PH_PULSE;
            cnt_q    <= '0;
            plen_q   <= long_pulse_sel ? PLEN_LONG : PLEN_SHORT;
            supply_q <= 1'b0;
            err_q    <= 1'b0;
            cause_q  <= CAUSE_NONE;
        end else begin
            mode_q   <= mode_d;
            phase_q  <= phase_d;
            cnt_q    <= cnt_d;
            plen_q   <= plen_d;
            supply_q <= supply_d;
            err_q    <= esc;
            if (esc) begin
                cause_q <= esc_cause;
            end
        end
    end

    // Output drive: own pulse, or undervoltage hold while still supervising.
    always_comb begin
        rst_line_drive = (phase_q == PH_PULSE) ||
                         (uv_flag && mode_q != MODE_FAILSAFE && mode_q != MODE_NORMAL);
        mode           = mode_q;
        supply_off     = supply_q;
        err_pulse      = err_q;
        err_cause      = cause_q;
    end

endmodule

// File: rtl/brg_checker.sv
// Temporal checks on the supervisor's ports, attached to every instance.
// Assumes: mode encodings from brg_pkg.
module brg_checker (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] mode,
    input logic       rst_line_drive,
    input logic       supply_off,
    input logic       wr_permit,
    input logic       err_pulse
);

    import brg_pkg::*;

    a_r10_err_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse |=> !err_pulse);

    a_r10_escalation_flagged: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != $past(mode)) && (mode != MODE_NORMAL) |-> err_pulse);

    a_r6_failsafe_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_FAILSAFE) |=> (mode == MODE_FAILSAFE));

    a_r6_failsafe_line_free: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_FAILSAFE) |-> !rst_line_drive);

    a_r4_normal_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_NORMAL) |=> (mode == MODE_NORMAL));

    a_r8_supply_off_in_failsafe: assert property (@(posedge clk) disable iff (!rst_n)
        supply_off |-> (mode == MODE_FAILSAFE));

    a_r9_no_write_in_failsafe: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_FAILSAFE) |-> !wr_permit);

endmodule

bind boot_reset_guard brg_checker i_brg_checker (
    .clk            (clk),
    .rst_n          (rst_n),
    .mode           (mode),
    .rst_line_drive (rst_line_drive),
    .supply_off     (supply_off),
    .wr_permit      (wr_permit),
    .err_pulse      (err_pulse)
);

// File: tb/test_boot_reset_guard.sv
// Bench: behavioural reference model compared on every clock, plus
// scenario checks for each requirement.
module test_boot_reset_guard;

    localparam int MON   = 64;
    localparam int START = 96;
    localparam int PS    = 6;
    localparam int PL    = 20;
    localparam int AW    = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          uv_flag = 1'b0;
    logic          init_strobe = 1'b0;
    logic          long_pulse_sel = 1'b0;
    logic          wr_req = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic          ext_low = 1'b0;
    logic          rst_line_in;
    logic          rst_line_drive, supply_off, wr_permit, err_pulse;
    logic [1:0]    mode;
    logic [2:0]    err_cause;

    int vectors = 0;
    int misses = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    assign rst_line_in = ~(rst_line_drive | ext_low);

    boot_reset_guard #(
        .MON_CYCLES (MON), .START_CYCLES (START), .PULSE_SHORT (PS),
        .PULSE_LONG (PL), .SYNC_STAGES (2), .ADDR_W (AW), .GP_BASE (0),
        .GP_COUNT (4), .MODE_ADDR (8), .SPECIAL_ADDR (9)
    ) i_boot_reset_guard (
        .clk (clk), .rst_n (rst_n), .rst_line_in (rst_line_in),
        .uv_flag (uv_flag), .init_strobe (init_strobe),
        .long_pulse_sel (long_pulse_sel), .wr_req (wr_req), .wr_addr (wr_addr),
        .rst_line_drive (rst_line_drive), .mode (mode), .supply_off (supply_off),
        .wr_permit (wr_permit), .err_pulse (err_pulse), .err_cause (err_cause)
    );

    // Reference model state.
    int m_mode, m_phase, m_cnt, m_plen, m_cause;
    bit m_sup, m_err, m_s1, m_s2, m_prev, m_spec;

    function automatic bit m_drive();
        return (m_phase == 0) || (uv_flag && m_mode != 3 && m_mode != 2);
    endfunction

    function automatic bit m_permit();
        bit ok;
        ok = (wr_addr < 4) || (wr_addr == 8) || (wr_addr == 9 && !m_spec);
        return wr_req && (m_mode == 2 || (m_phase == 2 && ok));
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            misses++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Reference model step on each rising edge.
    always @(posedge clk) begin
        bit pin, fall, esc;
        int ec;
        pin = !(m_drive() || ext_low);
        if (!rst_n) begin
            m_mode = 0; m_phase = 0; m_cnt = 0; m_plen = long_pulse_sel ? PL : PS;
            m_cause = 0; m_sup = 0; m_err = 0; m_s1 = 0; m_s2 = 0; m_prev = 0; m_spec = 0;
        end else begin
            fall = m_prev && !m_s2;
            esc = 0; ec = 0;
            if (m_permit() && wr_addr == 9) m_spec = 1;
            case (m_phase)
                0: begin m_cnt++; if (m_cnt == m_plen) m_phase = 1; end
                1: begin
                    if (m_s2) begin m_phase = 2; m_cnt = 0; end
                    else if (m_cnt == MON - 1) begin esc = 1; ec = uv_flag ? 4 : 1; end
                    else m_cnt++;
                end
                2: begin
                    if (fall) begin esc = 1; ec = 3; end
                    else if (init_strobe) begin m_phase = 3; m_mode = 2; end
                    else if (m_cnt == START - 1) begin esc = 1; ec = 2; end
                    else m_cnt++;
                end
                default: ;
            endcase
            m_err = esc;
            if (esc) begin
                m_cause = ec;
                if (ec == 4 || m_mode == 1) begin
                    m_mode = 3; m_phase = 3; m_sup = (ec == 4);
                end else begin
                    m_mode = 1; m_phase = 0; m_cnt = 0; m_plen = PL;
                end
            end
            m_prev = m_s2; m_s2 = m_s1; m_s1 = pin;
        end
    end

    // Every-cycle comparison, late in the cycle after inputs settle.
    always @(posedge clk) begin
        #15;
        if (!done) begin
            check("R4 mode", mode, m_mode);
            check("R2 line drive", rst_line_drive, m_drive());
            check("R8 supply_off", supply_off, m_sup);
            check("R10 err_pulse", err_pulse, m_err);
            check("R10 err_cause", err_cause, m_cause);
            check("R9 wr_permit", wr_permit, m_permit());
        end
    end

    task automatic do_reset(input bit sel);
        @(negedge clk);
        rst_n = 1'b0; long_pulse_sel = sel;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wait_mode(input int target, input string tag);
        int n = 0;
        while (mode != target && n < 400) begin @(negedge clk); n++; end
        check({tag, " mode reached"}, mode, target);
    endtask

    task automatic wait_release();
        int n = 0;
        while (rst_line_drive && n < 100) begin @(negedge clk); n++; end
        repeat (10) @(negedge clk);
    endtask

    task automatic try_write(input int a, input int exp, input string tag);
        @(negedge clk);
        wr_req = 1'b1; wr_addr = AW'(a);
        #1 check(tag, wr_permit, exp);
        @(negedge clk);
        wr_req = 1'b0;
    endtask

    task automatic glitch();
        @(negedge clk); ext_low = 1'b1;
        repeat (4) @(negedge clk); ext_low = 1'b0;
    endtask

    initial begin
        int w;
        // Scenario: short pulse, window writes, successful initialization.
        do_reset(1'b0);
        check("R1 mode", mode, 0); check("R1 drive", rst_line_drive, 1);
        check("R1 supply_off", supply_off, 0); check("R1 cause", err_cause, 0);
        check("R1 err_pulse", err_pulse, 0);
        w = 0;
        while (rst_line_drive) begin w++; @(negedge clk); end
        check("R2 short pulse width", w, PS);
        repeat (10) @(negedge clk);
        try_write(2, 1, "R9 gp write in window");
        try_write(5, 0, "R9 other write in window");
        try_write(8, 1, "R9 mode write in window");
        try_write(9, 1, "R9 first special write");
        try_write(9, 0, "R9 second special write");
        @(negedge clk); init_strobe = 1'b1;
        @(negedge clk); init_strobe = 1'b0;
        check("R4 normal after init", mode, 2);
        try_write(5, 1, "R9 any write in normal");
        repeat (20) @(negedge clk);
        check("R4 normal holds", mode, 2);

        // Scenario: long pulse, init timeout, then glitch in Restart.
        do_reset(1'b1);
        w = 0;
        while (rst_line_drive) begin w++; @(negedge clk); end
        check("R2 long pulse width", w, PL);
        wait_mode(1, "R5");
        check("R5 cause timeout", err_cause, 2);
        check("R10 err_pulse on escalation", err_pulse, 1);
        @(negedge clk);
        check("R10 err_pulse drops", err_pulse, 0);
        check("R5 restart drives line", rst_line_drive, 1);
        wait_release();
        glitch();
        wait_mode(3, "R6");
        check("R7 cause glitch", err_cause, 3);
        check("R6 line free", rst_line_drive, 0);
        try_write(0, 0, "R9 write in failsafe");
        repeat (50) @(negedge clk);
        check("R6 failsafe sticky", mode, 3);

        // Scenario: line clamped externally.
        ext_low = 1'b1;
        do_reset(1'b0);
        wait_mode(1, "R3");
        check("R3 cause clamp", err_cause, 1);
        wait_mode(3, "R6");
        check("R6 clamp in restart", err_cause, 1);
        check("R8 no supply off on clamp", supply_off, 0);
        ext_low = 1'b0;

        // Scenario: undervoltage.
        uv_flag = 1'b1;
        do_reset(1'b0);
        repeat (PS + 3) @(negedge clk);
        check("R8 uv holds line", rst_line_drive, 1);
        wait_mode(3, "R8");
        check("R8 cause undervoltage", err_cause, 4);
        check("R8 supply off", supply_off, 1);
        uv_flag = 1'b0;
        do_reset(1'b0);
        check("R6 left by reset", mode, 0);
        check("R6 supply restored", supply_off, 0);

        // Scenario: glitch in Start-up window.
        wait_release();
        glitch();
        wait_mode(1, "R7");
        check("R7 startup glitch cause", err_cause, 3);
        try_write(0, 0, "R9 write during pulse");
        repeat (5) @(negedge clk);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        done = 1'b1;
        vectors++; misses++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

endmodule